// File: doc/BRIEF.md
# Shared-Ownership GPIO Bank Controller

This block holds the control and data state for a bank of 32 general-purpose pins that several bus masters and many on-chip peripherals share. Every pin output comes from exactly one source at a time: one of twelve peripheral functions, chosen by a 4-bit selector, or the CPU-owned output latch. A per-pin owner bit records which of two CPU masters may change that pin's latch bit. A co-processor acts on behalf of the primary CPU.

Configuration covers the function selectors, the owner bits, open-drain, output enable and pull enable. Only the primary master may write it; a write from any other master is dropped. Data writes can replace the latch or set, clear or toggle single bits through alias addresses. In every case they reach only the bits whose owner matches the writing CPU. The input path is separate from the output path: the pad level passes through a two-flop synchroniser into a status register whatever the selector and ownership settings. A readback register returns the latch contents.

The register port is single-cycle. Writes take effect at the clock edge on which they are presented. Reads are combinational from the address. Each access carries a 2-bit master ID: 0 is the primary CPU, 1 the co-processor, 2 the second CPU and 3 any other master.

Top module: `gpio_bank_mux`

## Requirements
- R1: After reset every selector is 0, and all owner, open-drain, output-enable and pull bits are 0. The latch is 0, pad_oe_o is all 0 and pad_out_o is all 0.
- R2: A write to a configuration address (0 to 7) with a master ID other than 0 leaves every configuration register unchanged.
- R3: A data-group write (addresses 8 to 11) changes only latch bits owned by the writer. Owner bit 0 means the primary CPU (IDs 0 and 1) owns the pin, and owner bit 1 means the second CPU (ID 2) owns it.
- R4: The data operations act on owned bits. Address 8 loads the write data. Address 9 forces each 1-bit to 1, address 10 forces each 1-bit to 0, and address 11 inverts each 1-bit. Bits written as 0 leave the latch unchanged for addresses 9 to 11.
- R5: A pin whose selector is 0 or 13 to 15 drives the latch bit, enabled by its output-enable bit. A selector k in 1 to 12 drives peripheral function k-1's value and enable for that pin.
- R6: For a pin in open-drain mode, pad_out_o is 0 and pad_oe_o is high only when the source is enabled and its value is 0. The rule is the same whether the source is the latch or a peripheral.
- R7: Address 12 reads the latch contents, independent of the pad level.
- R8: Addresses 8 and 13 read pad_in_i as it was two rising edges earlier, whatever the selector or owner settings.
- R9: The co-processor (ID 1) has the primary CPU's data rights. Data writes from ID 3 leave the latch unchanged.
- R10: Address map: selectors for pins 8r to 8r+7 sit at address r (0 to 3), with pin 8r+i in bits 4i+3:4i. Owner is at 4, open-drain at 5, output enable at 6 and pull at 7, one bit per pin. Configuration addresses read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_wen_i | input | 1 | Write strobe |
| bus_mid_i | input | 2 | Master ID of the access |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| periph_do_i | input | 12x32 | Peripheral function output values per pin |
| periph_oe_i | input | 12x32 | Peripheral function output enables per pin |
| pad_in_i | input | 32 | Raw pad levels |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad driver enables |
| pad_pull_o | output | 32 | Pad pull enables |

## Verification
Writes land at the edge where the strobe is sampled. The latch, configuration registers and pad outputs are therefore due one edge after the strobe. Peripheral inputs reach the pads in the same cycle, without a register. Pin status lags pad_in_i by two edges. The bench drives every input on the falling edge and samples outputs on the following falling edge, or one nanosecond after setting a read address. For the status path it samples after one edge, where the old value must still be visible, and again after two edges, where the new value is due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned MID_W  = 2;
  localparam int unsigned ADDR_W = 4;

  localparam logic [MID_W-1:0] MID_PRIMARY = 2'd0;
  localparam logic [MID_W-1:0] MID_COPROC  = 2'd1;
  localparam logic [MID_W-1:0] MID_SECOND  = 2'd2;
  localparam logic [MID_W-1:0] MID_OTHER   = 2'd3;

  localparam logic [ADDR_W-1:0] RA_OWNER  = 4'd4;
  localparam logic [ADDR_W-1:0] RA_ODRAIN = 4'd5;
  localparam logic [ADDR_W-1:0] RA_DIR    = 4'd6;
  localparam logic [ADDR_W-1:0] RA_PULL   = 4'd7;
  localparam logic [ADDR_W-1:0] RA_DATA   = 4'd8;
  localparam logic [ADDR_W-1:0] RA_SET    = 4'd9;
  localparam logic [ADDR_W-1:0] RA_CLR    = 4'd10;
  localparam logic [ADDR_W-1:0] RA_TOG    = 4'd11;
  localparam logic [ADDR_W-1:0] RA_LATCH  = 4'd12;
  localparam logic [ADDR_W-1:0] RA_STATUS = 4'd13;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned SEL_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wen_i,
  input  logic [MID_W-1:0]             mid_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NPINS-1:0]             wdata_i,
  output logic [NPINS-1:0][SEL_W-1:0]  mux_q,
  output logic [NPINS-1:0]             own_q,
  output logic [NPINS-1:0]             od_q,
  output logic [NPINS-1:0]             dir_q,
  output logic [NPINS-1:0]             pull_q
);
  localparam int unsigned PINS_PER_REG = NPINS / SEL_W;
  localparam int unsigned MUX_REGS     = NPINS / PINS_PER_REG;

  logic cfg_wr_ok;
  assign cfg_wr_ok = wen_i && (mid_i == MID_PRIMARY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q  <= '0;
      own_q  <= '0;
      od_q   <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else if (cfg_wr_ok) begin
      for (int r = 0; r < MUX_REGS; r++) begin
        if (addr_i == ADDR_W'(r)) begin
          for (int i = 0; i < PINS_PER_REG; i++) begin
            mux_q[r*PINS_PER_REG+i] <= wdata_i[i*SEL_W +: SEL_W];
          end
        end
      end
      if (addr_i == RA_OWNER)  own_q  <= wdata_i;
      if (addr_i == RA_ODRAIN) od_q   <= wdata_i;
      if (addr_i == RA_DIR)    dir_q  <= wdata_i;
      if (addr_i == RA_PULL)   pull_q <= wdata_i;
    end
  end

  // R2: configuration is frozen against any master other than the primary one
  assert_cfg_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && mid_i != MID_PRIMARY) |=>
      ($stable(mux_q) && $stable(own_q) && $stable(od_q) && $stable(dir_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  own_i,
  output logic [NPINS-1:0]  latch_q
);
  // Bits the writing master may touch, given per-pin owner bits.
  function automatic logic [NPINS-1:0] writable(input logic [MID_W-1:0] mid,
                                                input logic [NPINS-1:0] own);
    case (mid)
      MID_PRIMARY, MID_COPROC: writable = ~own;
      MID_SECOND:              writable = own;
      default:                 writable = '0;
    endcase
  endfunction

  // New latch value for one data-group operation restricted to a mask.
  function automatic logic [NPINS-1:0] apply_op(input logic [ADDR_W-1:0] op,
                                                input logic [NPINS-1:0] cur,
                                                input logic [NPINS-1:0] wd,
                                                input logic [NPINS-1:0] msk);
    case (op)
      RA_DATA: apply_op = (cur & ~msk) | (wd & msk);
      RA_SET:  apply_op = cur | (wd & msk);
      RA_CLR:  apply_op = cur & ~(wd & msk);
      RA_TOG:  apply_op = cur ^ (wd & msk);
      default: apply_op = cur;
    endcase
  endfunction

  logic [NPINS-1:0] own_mask;
  logic             data_wr;
  assign own_mask = writable(mid_i, own_i);
  assign data_wr  = wen_i && (addr_i >= RA_DATA) && (addr_i <= RA_TOG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= '0;
    else if (data_wr) latch_q <= apply_op(addr_i, latch_q, wdata_i, own_mask);
  end

  // R3: bits outside the writer's ownership never move on a data write
  assert_unowned_bits_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> (((latch_q ^ $past(latch_q)) & ~$past(own_mask)) == '0));

  // R9: a master without data rights cannot alter the latch
  assert_other_master_inert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_i && mid_i == MID_OTHER) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NPERIPH = 12
) (
  input  logic [NPINS-1:0][SEL_W-1:0]   mux_i,
  input  logic [NPINS-1:0]              dir_i,
  input  logic [NPINS-1:0]              od_i,
  input  logic [NPINS-1:0]              latch_i,
  input  logic [NPERIPH-1:0][NPINS-1:0] periph_do_i,
  input  logic [NPERIPH-1:0][NPINS-1:0] periph_oe_i,
  output logic [NPINS-1:0]              gpio_sel_o,
  output logic [NPINS-1:0]              pad_out_o,
  output logic [NPINS-1:0]              pad_oe_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic src_v, src_en, is_gpio;
    always_comb begin
      src_v   = latch_i[p];
      src_en  = dir_i[p];
      is_gpio = 1'b1;
      for (int k = 0; k < NPERIPH; k++) begin
        if (mux_i[p] == SEL_W'(k + 1)) begin
          src_v   = periph_do_i[k][p];
          src_en  = periph_oe_i[k][p];
          is_gpio = 1'b0;
        end
      end
    end
    assign gpio_sel_o[p] = is_gpio;
    assign pad_out_o[p]  = od_i[p] ? 1'b0 : src_v;
    assign pad_oe_o[p]   = od_i[p] ? (src_en & ~src_v) : src_en;
  end
endmodule

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NPERIPH = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bus_wen_i,
  input  logic [MID_W-1:0]              bus_mid_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [NPINS-1:0]              bus_wdata_i,
  output logic [NPINS-1:0]              bus_rdata_o,
  input  logic [NPERIPH-1:0][NPINS-1:0] periph_do_i,
  input  logic [NPERIPH-1:0][NPINS-1:0] periph_oe_i,
  input  logic [NPINS-1:0]              pad_in_i,
  output logic [NPINS-1:0]              pad_out_o,
  output logic [NPINS-1:0]              pad_oe_o,
  output logic [NPINS-1:0]              pad_pull_o
);
  localparam int unsigned PINS_PER_REG = NPINS / SEL_W;
  localparam int unsigned MUX_REGS     = NPINS / PINS_PER_REG;

  logic [NPINS-1:0][SEL_W-1:0] mux_q;
  logic [NPINS-1:0] own_q, od_q, dir_q, pull_q, latch_q, gpio_sel;
  logic [NPINS-1:0] sync1_q, status_q;
  logic [1:0]       sync_age;

  gpio_cfg_regs #(.NPINS(NPINS), .SEL_W(SEL_W)) u_cfg (
    .clk_i, .rst_ni, .wen_i(bus_wen_i), .mid_i(bus_mid_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .mux_q, .own_q, .od_q, .dir_q, .pull_q);

  gpio_data_latch #(.NPINS(NPINS)) u_latch (
    .clk_i, .rst_ni, .wen_i(bus_wen_i), .mid_i(bus_mid_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .own_i(own_q), .latch_q);

  gpio_pad_mux #(.NPINS(NPINS), .SEL_W(SEL_W), .NPERIPH(NPERIPH)) u_pads (
    .mux_i(mux_q), .dir_i(dir_q), .od_i(od_q), .latch_i(latch_q),
    .periph_do_i, .periph_oe_i, .gpio_sel_o(gpio_sel), .pad_out_o, .pad_oe_o);

  assign pad_pull_o = pull_q;

  // Input path: two-flop synchroniser, independent of all output settings.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q  <= '0;
      status_q <= '0;
      sync_age <= '0;
    end else begin
      sync1_q  <= pad_in_i;
      status_q <= sync1_q;
      if (sync_age != 2'd2) sync_age <= sync_age + 2'd1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int r = 0; r < MUX_REGS; r++) begin
      if (bus_addr_i == ADDR_W'(r)) begin
        for (int i = 0; i < PINS_PER_REG; i++) begin
          bus_rdata_o[i*SEL_W +: SEL_W] = mux_q[r*PINS_PER_REG+i];
        end
      end
    end
    case (bus_addr_i)
      RA_OWNER:          bus_rdata_o = own_q;
      RA_ODRAIN:         bus_rdata_o = od_q;
      RA_DIR:            bus_rdata_o = dir_q;
      RA_PULL:           bus_rdata_o = pull_q;
      RA_DATA, RA_STATUS: bus_rdata_o = status_q;
      RA_LATCH:          bus_rdata_o = latch_q;
      default: ;
    endcase
  end

  // R8: pin status trails the pad by exactly two edges
  assert_status_two_edges_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_age == 2'd2) |-> (status_q == $past(pad_in_i, 2)));

  // R5: push-pull pins in GPIO mode show the latch on the pad
  assert_gpio_path_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gpio_sel & ~od_q & (pad_out_o ^ latch_q)) == '0));
endmodule

// File: tb/sim_gpio_bank_mux.sv
`timescale 1ns/1ps
module sim_gpio_bank_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0;
  logic [1:0] mid = 2'd0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0][31:0] pdo = '0;
  logic [11:0][31:0] poe = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pull;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_mux u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wen_i(wen), .bus_mid_i(mid), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .periph_do_i(pdo), .periph_oe_i(poe),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pull_o(pad_pull));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; mid = m; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_check("R1 cfg reset", 4'(a), 32'h0);
    rd_check("R1 latch reset", 4'd12, 32'h0);
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 pad_out reset", pad_out, 32'h0);
  endtask

  task automatic t_lock;
    wr(2'd2, 4'd6, 32'hFFFF_FFFF);
    wr(2'd1, 4'd0, 32'h1111_1111);
    rd_check("R2 dir locked", 4'd6, 32'h0);
    rd_check("R2 mux locked", 4'd0, 32'h0);
    wr(2'd0, 4'd6, 32'hFFFF_FFFF);
    wr(2'd0, 4'd7, 32'h0000_00F0);
    rd_check("R10 dir readback", 4'd6, 32'hFFFF_FFFF);
    check("R10 pull pins", pad_pull, 32'h0000_00F0);
  endtask

  task automatic t_ownership;
    wr(2'd0, 4'd8, 32'hA5A5_A5A5);
    rd_check("R4 data load", 4'd12, 32'hA5A5_A5A5);
    check("R5 gpio pad", pad_out, 32'hA5A5_A5A5);
    wr(2'd2, 4'd8, 32'h0);
    rd_check("R3 unowned write", 4'd12, 32'hA5A5_A5A5);
    wr(2'd0, 4'd4, 32'h0000_FFFF);
    wr(2'd2, 4'd8, 32'hFFFF_FFFF);
    rd_check("R3 second cpu low half", 4'd12, 32'hA5A5_FFFF);
    wr(2'd0, 4'd8, 32'h0);
    rd_check("R3 primary high half", 4'd12, 32'h0000_FFFF);
    wr(2'd1, 4'd9, 32'hFFFF_0000);
    rd_check("R9 coproc set", 4'd12, 32'hFFFF_FFFF);
    wr(2'd3, 4'd10, 32'hFFFF_FFFF);
    rd_check("R9 other master", 4'd12, 32'hFFFF_FFFF);
    wr(2'd0, 4'd4, 32'h0);
  endtask

  task automatic t_alias;
    wr(2'd0, 4'd10, 32'h0F0F_0F0F);
    rd_check("R4 clear", 4'd12, 32'hF0F0_F0F0);
    wr(2'd0, 4'd9, 32'h0000_0003);
    rd_check("R4 set", 4'd12, 32'hF0F0_F0F3);
    wr(2'd0, 4'd11, 32'hFF00_00FF);
    rd_check("R4 toggle", 4'd12, 32'h0FF0_F00C);
  endtask

  task automatic t_periph;
    pdo[0] = 32'h1;   poe[0] = 32'h1;
    pdo[11] = 32'h0;  poe[11] = 32'h2;
    wr(2'd0, 4'd0, 32'h0000_0DC1);
    rd_check("R10 mux readback", 4'd0, 32'h0000_0DC1);
    check("R5 periph values", {28'h0, pad_out[3:0]}, 32'hD);
    check("R5 periph enables", {28'h0, pad_oe[3:0]}, 32'hF);
    @(negedge clk);
    poe[0] = 32'h0;
    #1;
    check("R5 periph enable off", {28'h0, pad_oe[3:0]}, 32'hE);
    wr(2'd0, 4'd0, 32'h0);
  endtask

  task automatic t_opendrain;
    wr(2'd0, 4'd5, 32'h0000_000F);
    wr(2'd0, 4'd8, 32'h0000_000A);
    check("R6 od enables", pad_oe, 32'hFFFF_FFF5);
    check("R6 od values", pad_out, 32'h0);
    pdo[0] = 32'h0; poe[0] = 32'h1;
    wr(2'd0, 4'd0, 32'h0000_0001);
    check("R6 od periph low", {31'h0, pad_oe[0]}, 32'h1);
    wr(2'd0, 4'd0, 32'h0);
    wr(2'd0, 4'd5, 32'h0);
  endtask

  task automatic t_status;
    @(negedge clk);
    pad_in = 32'h1234_5678;
    @(negedge clk);
    rd_check("R8 status one edge", 4'd13, 32'h0);
    @(negedge clk);
    rd_check("R8 status two edges", 4'd13, 32'h1234_5678);
    rd_check("R8 data reads pad", 4'd8, 32'h1234_5678);
    rd_check("R7 readback is latch", 4'd12, 32'h0000_000A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    t_lock;
    t_ownership;
    t_alias;
    t_periph;
    t_opendrain;
    t_status;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule